// File: doc/BRIEF.md
# SPI Radio Command Decoder

This block is the device-side SPI slave of a low-rate wireless transceiver. A host frames each command with an active-low chip select. The block decodes the first MOSI byte of the frame as an opcode. That opcode selects one of these commands: a single register write, a memory read or write with an auto-incrementing address, a transmit FIFO load, a receive FIFO drain, or a one-byte strobe. While the opcode byte shifts in, the block shifts a status byte out on MISO.

A byte-wide RAM holds three regions. The register file sits at the bottom. A 128-byte transmit FIFO sits at 0x100, and a 128-byte receive FIFO sits at 0x180. The radio core pops transmit bytes and pushes receive bytes through a narrow side port. The block drives single-cycle flush, receive-on, transmit-after-CCA and RF-off strobes to that core.

SPI is mode 0: MOSI is sampled on the rising SCLK edge and MISO changes on the falling edge. SCLK, MOSI and chip select are oversampled by the block clock, which must run at least eight times faster than SCLK.

Top module: `radio_cmd_decoder`

## Requirements
- R1: The first MISO byte of every frame is status. Bit 7 is `xosc_stable_i`, bit 6 is `rssi_valid_i`, bit 3 is the transmit underflow flag, and the other bits are 0. Every later MISO byte that is not read data is 0x00.
- R2: The opcode 0xC0 | a, where a is 0x00–0x3F, writes the next MOSI byte to address a. Any further bytes in that frame change nothing.
- R3: The opcode 0x20 | A[11:8], followed by A[7:0], writes each later MOSI byte to A, A+1, A+2 and so on.
- R4: The opcode 0x10 | A[11:8], followed by A[7:0], returns on MISO the bytes at A, A+1, A+2 and so on, one per later byte.
- R5: An address at or above RAM_BYTES (512) reads as 0x00. A write to such an address is dropped and does not alias into the implemented RAM.
- R6: The opcode 0x3A appends each later MOSI byte to the transmit FIFO, stored from RAM offset 0x100. The radio side sees the bytes in order on `radio_tx_data_o` and removes them with `radio_tx_rd_i`. It reads 0x00 when the FIFO is empty.
- R7: A byte sent to a full transmit FIFO (128 entries) is discarded, and the stored contents are unchanged.
- R8: The opcode 0x30 returns receive FIFO bytes in push order and returns 0x00 once the FIFO is empty. A byte is removed only after all eight of its bits were clocked out. A byte staged for output when chip select rises stays in the FIFO.
- R9: The strobe opcodes each raise one output for one clock after the opcode byte completes: 0x48 raises `flush_tx_o` and empties the transmit FIFO, 0x47 raises `flush_rx_o` and empties the receive FIFO, 0x42 raises `rx_on_o`, 0x44 raises `tx_cca_o`, and 0x45 raises `rf_off_o`. At most one strobe is high at a time.
- R10: An opcode outside R2–R9 (for example 0x80), and the no-op 0x00, return status and then ignore every later byte of the frame, including bytes that look like opcodes.
- R11: Raising chip select at any point, even mid-byte, ends the command. The next frame starts with a fresh opcode byte.
- R12: A radio-side pop of an empty transmit FIFO sets the underflow status bit. The bit stays set until a transmit flush clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, at least 8x SCLK |
| rst_ni | input | 1 | Asynchronous active-low reset |
| spi_sclk_i | input | 1 | SPI clock, idle low |
| spi_mosi_i | input | 1 | SPI data from host |
| spi_csn_i | input | 1 | SPI chip select, active low |
| spi_miso_o | output | 1 | SPI data to host, 0 when deselected |
| xosc_stable_i | input | 1 | Oscillator stable flag for status bit 7 |
| rssi_valid_i | input | 1 | RSSI valid flag for status bit 6 |
| radio_tx_rd_i | input | 1 | Radio core pops one transmit byte |
| radio_tx_data_o | output | 8 | Head of transmit FIFO, 0x00 when empty |
| radio_rx_wr_i | input | 1 | Radio core pushes one received byte |
| radio_rx_data_i | input | 8 | Received byte to push |
| flush_tx_o | output | 1 | Transmit flush strobe |
| flush_rx_o | output | 1 | Receive flush strobe |
| rx_on_o | output | 1 | Receive enable strobe |
| tx_cca_o | output | 1 | Transmit-after-CCA strobe |
| rf_off_o | output | 1 | RF off strobe |

## Verification
The bench builds the block with its defaults: RAM_BYTES of 512, FIFO_DEPTH of 128 and two synchronizer stages. With these values, the full transmit FIFO can be reached by one SPI frame of 129 data bytes. The pointer wrap onto slot 0 is then exposed, because the dropped byte would overwrite the first entry. The 512-byte RAM puts both FIFO regions at their fixed offsets. It leaves 0x200 as the first unimplemented address, so an aliasing write to 0x000 shows up in a readback. An SCLK half period of eight clocks leaves margin over the synchronizer and edge-detect latency before each MISO bit is sampled.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
  localparam int ADDR_W = 12;

  localparam logic [7:0] OP_NOP      = 8'h00;
  localparam logic [7:0] OP_TX_LOAD  = 8'h3A;
  localparam logic [7:0] OP_RX_DRAIN = 8'h30;
  localparam logic [7:0] OP_FLUSH_RX = 8'h47;
  localparam logic [7:0] OP_FLUSH_TX = 8'h48;
  localparam logic [7:0] OP_RX_ON    = 8'h42;
  localparam logic [7:0] OP_TX_CCA   = 8'h44;
  localparam logic [7:0] OP_RF_OFF   = 8'h45;
  localparam logic [1:0] PFX_REG_WR  = 2'b11;
  localparam logic [3:0] PFX_MEM_WR  = 4'b0010;
  localparam logic [3:0] PFX_MEM_RD  = 4'b0001;

  typedef enum logic [2:0] {
    ST_OPCODE,
    ST_REG_DATA,
    ST_ADDR_LO,
    ST_MEM_WR,
    ST_MEM_RD,
    ST_TX_LOAD,
    ST_RX_DRAIN,
    ST_IGNORE
  } rcd_state_e;
endpackage

// File: rtl/rcd_spi_shift.sv
module rcd_spi_shift #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       mosi_i,
  input  logic       csn_i,
  input  logic [7:0] tx_byte_i,
  output logic       active_o,
  output logic       byte_done_o,
  output logic [7:0] rx_byte_o,
  output logic       load_o,
  output logic       miso_o
);
  logic [SYNC_STAGES-1:0] sclk_sync_q, mosi_sync_q, csn_sync_q;
  logic       sclk_d_q, act_d_q, miso_q, miso_n;
  logic [2:0] bit_q, bit_n;
  logic [6:0] sin_q, sin_n, sout_q, sout_n;
  logic       sclk_now, mosi_now, active, rise, fall, start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_sync_q <= '0;
      mosi_sync_q <= '0;
      csn_sync_q  <= '1;
    end else begin
      sclk_sync_q <= {sclk_sync_q[SYNC_STAGES-2:0], sclk_i};
      mosi_sync_q <= {mosi_sync_q[SYNC_STAGES-2:0], mosi_i};
      csn_sync_q  <= {csn_sync_q[SYNC_STAGES-2:0], csn_i};
    end
  end

  assign sclk_now = sclk_sync_q[SYNC_STAGES-1];
  assign mosi_now = mosi_sync_q[SYNC_STAGES-1];
  assign active   = ~csn_sync_q[SYNC_STAGES-1];
  assign rise     = sclk_now & ~sclk_d_q;
  assign fall     = ~sclk_now & sclk_d_q;
  assign start    = active & ~act_d_q;

  assign active_o    = active;
  assign byte_done_o = active & rise & (bit_q == 3'd7);
  assign rx_byte_o   = {sin_q, mosi_now};
  assign load_o      = start | (active & fall & (bit_q == 3'd0));
  assign miso_o      = miso_q;

  always_comb begin
    bit_n  = bit_q;
    sin_n  = sin_q;
    sout_n = sout_q;
    miso_n = miso_q;
    if (!active) begin
      bit_n  = 3'd0;
      miso_n = 1'b0;
    end else begin
      if (rise) begin
        bit_n = bit_q + 3'd1;
        sin_n = {sin_q[5:0], mosi_now};
      end
      if (load_o) begin
        miso_n = tx_byte_i[7];
        sout_n = tx_byte_i[6:0];
      end else if (fall) begin
        miso_n = sout_q[6];
        sout_n = {sout_q[5:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q <= 1'b0;
      act_d_q  <= 1'b0;
      bit_q    <= 3'd0;
      sin_q    <= '0;
      sout_q   <= '0;
      miso_q   <= 1'b0;
    end else begin
      sclk_d_q <= sclk_now;
      act_d_q  <= active;
      bit_q    <= bit_n;
      sin_q    <= sin_n;
      sout_q   <= sout_n;
      miso_q   <= miso_n;
    end
  end

  // R11: deselect clears the bit position and quiets MISO
  p_idle_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> (bit_q == 3'd0) && !miso_q);
endmodule

// File: rtl/rcd_fifo_ptr.sv
module rcd_fifo_ptr #(
  parameter int DEPTH = 128
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flush_i,
  input  logic                     push_i,
  input  logic                     pop_i,
  output logic [$clog2(DEPTH)-1:0] wr_idx_o,
  output logic [$clog2(DEPTH)-1:0] rd_idx_o,
  output logic                     wr_ok_o,
  output logic                     empty_o,
  output logic                     underflow_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          unf_q, unf_n, full, rd_ok;

  assign empty_o     = (cnt_q == '0);
  assign full        = (cnt_q == CW'(DEPTH));
  assign wr_ok_o     = push_i & ~full;
  assign rd_ok       = pop_i & ~empty_o;
  assign wr_idx_o    = wp_q;
  assign rd_idx_o    = rp_q;
  assign underflow_o = unf_q;

  always_comb begin
    if (flush_i) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
      unf_n = 1'b0;
    end else begin
      wp_n  = wp_q + PW'(wr_ok_o);
      rp_n  = rp_q + PW'(rd_ok);
      cnt_n = cnt_q + CW'(wr_ok_o) - CW'(rd_ok);
      unf_n = unf_q | (pop_i & empty_o);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      unf_q <= 1'b0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
      unf_q <= unf_n;
    end
  end

  // R7: a push into a full FIFO moves nothing
  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full && push_i && !pop_i && !flush_i |=> $stable(wp_q) && $stable(cnt_q));
  // R9: a flush leaves the FIFO empty
  p_flush_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o && !underflow_o);
  // R12: popping an empty FIFO raises the sticky flag
  p_underflow_set_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && empty_o && !flush_i |=> underflow_o);
endmodule

// File: rtl/rcd_cmd_fsm.sv
module rcd_cmd_fsm
  import rcd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              byte_done_i,
  input  logic [7:0]        rx_byte_i,
  input  logic              load_i,
  input  logic [7:0]        status_i,
  input  logic [7:0]        mem_rdata_i,
  input  logic [7:0]        rx_head_i,
  input  logic              rx_empty_i,
  output logic [7:0]        out_byte_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              mem_we_o,
  output logic              tx_push_o,
  output logic              rx_pop_o,
  output logic              flush_tx_o,
  output logic              flush_rx_o,
  output logic              rx_on_o,
  output logic              tx_cca_o,
  output logic              rf_off_o
);
  rcd_state_e        st_q, st_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              wr_mode_q, wr_mode_n, staged_q, staged_n;

  assign addr_o = addr_q;

  always_comb begin
    unique case (st_q)
      ST_OPCODE:   out_byte_o = status_i;
      ST_MEM_RD:   out_byte_o = mem_rdata_i;
      ST_RX_DRAIN: out_byte_o = rx_empty_i ? 8'h00 : rx_head_i;
      default:     out_byte_o = 8'h00;
    endcase
  end

  always_comb begin
    st_n       = st_q;
    addr_n     = addr_q;
    wr_mode_n  = wr_mode_q;
    staged_n   = staged_q;
    mem_we_o   = 1'b0;
    tx_push_o  = 1'b0;
    rx_pop_o   = 1'b0;
    flush_tx_o = 1'b0;
    flush_rx_o = 1'b0;
    rx_on_o    = 1'b0;
    tx_cca_o   = 1'b0;
    rf_off_o   = 1'b0;
    if (!active_i) begin
      st_n     = ST_OPCODE;
      staged_n = 1'b0;
    end else begin
      if (load_i) staged_n = (st_q == ST_RX_DRAIN) & ~rx_empty_i;
      if (byte_done_i) begin
        unique case (st_q)
          ST_OPCODE: begin
            st_n = ST_IGNORE;
            if (rx_byte_i[7:6] == PFX_REG_WR) begin
              addr_n = {{(ADDR_W-6){1'b0}}, rx_byte_i[5:0]};
              st_n   = ST_REG_DATA;
            end else if (rx_byte_i[7:4] == PFX_MEM_WR ||
                         rx_byte_i[7:4] == PFX_MEM_RD) begin
              addr_n    = {rx_byte_i[3:0], 8'h00};
              wr_mode_n = (rx_byte_i[7:4] == PFX_MEM_WR);
              st_n      = ST_ADDR_LO;
            end else begin
              unique case (rx_byte_i)
                OP_TX_LOAD:  st_n = ST_TX_LOAD;
                OP_RX_DRAIN: st_n = ST_RX_DRAIN;
                OP_FLUSH_TX: flush_tx_o = 1'b1;
                OP_FLUSH_RX: flush_rx_o = 1'b1;
                OP_RX_ON:    rx_on_o    = 1'b1;
                OP_TX_CCA:   tx_cca_o   = 1'b1;
                OP_RF_OFF:   rf_off_o   = 1'b1;
                default:     st_n = ST_IGNORE;
              endcase
            end
          end
          ST_REG_DATA: begin
            mem_we_o = 1'b1;
            st_n     = ST_IGNORE;
          end
          ST_ADDR_LO: begin
            addr_n = {addr_q[ADDR_W-1:8], rx_byte_i};
            st_n   = wr_mode_q ? ST_MEM_WR : ST_MEM_RD;
          end
          ST_MEM_WR: begin
            mem_we_o = 1'b1;
            addr_n   = addr_q + 1'b1;
          end
          ST_MEM_RD:  addr_n = addr_q + 1'b1;
          ST_TX_LOAD: tx_push_o = 1'b1;
          ST_RX_DRAIN: begin
            rx_pop_o = staged_q;
            staged_n = 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_OPCODE;
      addr_q    <= '0;
      wr_mode_q <= 1'b0;
      staged_q  <= 1'b0;
    end else begin
      st_q      <= st_n;
      addr_q    <= addr_n;
      wr_mode_q <= wr_mode_n;
      staged_q  <= staged_n;
    end
  end

  // R9: strobes never overlap
  p_strobe_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({flush_tx_o, flush_rx_o, rx_on_o, tx_cca_o, rf_off_o}));
  // R11: deselect returns the decoder to opcode phase
  p_abort_opcode_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> st_q == ST_OPCODE);
  // R10: an ignored frame touches no storage
  p_ignore_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_IGNORE |-> !mem_we_o && !tx_push_o && !rx_pop_o);
endmodule

// File: rtl/radio_cmd_decoder.sv
module radio_cmd_decoder
  import rcd_pkg::*;
#(
  parameter int RAM_BYTES   = 512,
  parameter int FIFO_DEPTH  = 128,
  parameter int SYNC_STAGES = 2,
  parameter int TX_BASE     = 'h100,
  parameter int RX_BASE     = 'h180
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       spi_sclk_i,
  input  logic       spi_mosi_i,
  input  logic       spi_csn_i,
  output logic       spi_miso_o,
  input  logic       xosc_stable_i,
  input  logic       rssi_valid_i,
  input  logic       radio_tx_rd_i,
  output logic [7:0] radio_tx_data_o,
  input  logic       radio_rx_wr_i,
  input  logic [7:0] radio_rx_data_i,
  output logic       flush_tx_o,
  output logic       flush_rx_o,
  output logic       rx_on_o,
  output logic       tx_cca_o,
  output logic       rf_off_o
);
  localparam int RW = $clog2(RAM_BYTES);
  localparam int PW = $clog2(FIFO_DEPTH);
  localparam logic [RW-1:0] TXB = RW'(TX_BASE);
  localparam logic [RW-1:0] RXB = RW'(RX_BASE);

  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic              active, byte_done, load;
  logic [7:0]        rx_byte, out_byte, status, mem_rdata, rx_head;
  logic [ADDR_W-1:0] addr;
  logic              mem_we, tx_push, rx_pop, in_range, spi_we;
  logic [PW-1:0]     tx_wi, tx_ri, rx_wi, rx_ri;
  logic              tx_wr_ok, tx_empty, tx_unf, rx_wr_ok, rx_empty, rx_unf;
  logic [7:0]        ram_q [RAM_BYTES];

  rcd_spi_shift #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_n), .sclk_i(spi_sclk_i), .mosi_i(spi_mosi_i),
    .csn_i(spi_csn_i), .tx_byte_i(out_byte), .active_o(active),
    .byte_done_o(byte_done), .rx_byte_o(rx_byte), .load_o(load),
    .miso_o(spi_miso_o));

  rcd_cmd_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_n), .active_i(active), .byte_done_i(byte_done),
    .rx_byte_i(rx_byte), .load_i(load), .status_i(status),
    .mem_rdata_i(mem_rdata), .rx_head_i(rx_head), .rx_empty_i(rx_empty),
    .out_byte_o(out_byte), .addr_o(addr), .mem_we_o(mem_we),
    .tx_push_o(tx_push), .rx_pop_o(rx_pop), .flush_tx_o(flush_tx_o),
    .flush_rx_o(flush_rx_o), .rx_on_o(rx_on_o), .tx_cca_o(tx_cca_o),
    .rf_off_o(rf_off_o));

  rcd_fifo_ptr #(.DEPTH(FIFO_DEPTH)) u_tx_ptr (
    .clk_i(clk_i), .rst_ni(rst_n), .flush_i(flush_tx_o), .push_i(tx_push),
    .pop_i(radio_tx_rd_i), .wr_idx_o(tx_wi), .rd_idx_o(tx_ri),
    .wr_ok_o(tx_wr_ok), .empty_o(tx_empty), .underflow_o(tx_unf));

  rcd_fifo_ptr #(.DEPTH(FIFO_DEPTH)) u_rx_ptr (
    .clk_i(clk_i), .rst_ni(rst_n), .flush_i(flush_rx_o), .push_i(radio_rx_wr_i),
    .pop_i(rx_pop), .wr_idx_o(rx_wi), .rd_idx_o(rx_ri),
    .wr_ok_o(rx_wr_ok), .empty_o(rx_empty), .underflow_o(rx_unf));

  assign status    = {xosc_stable_i, rssi_valid_i, 2'b00, tx_unf, 1'b0, 1'b0, rx_unf & 1'b0};
  assign in_range  = ({1'b0, addr} < (ADDR_W + 1)'(RAM_BYTES));
  assign spi_we    = mem_we & in_range;
  assign mem_rdata = in_range ? ram_q[addr[RW-1:0]] : 8'h00;
  assign rx_head   = ram_q[RXB + RW'(rx_ri)];
  assign radio_tx_data_o = tx_empty ? 8'h00 : ram_q[TXB + RW'(tx_ri)];

  always_ff @(posedge clk_i) begin
    if (spi_we)   ram_q[addr[RW-1:0]]     <= rx_byte;
    if (tx_wr_ok) ram_q[TXB + RW'(tx_wi)] <= rx_byte;
    if (rx_wr_ok) ram_q[RXB + RW'(rx_wi)] <= radio_rx_data_i;
  end
endmodule

// File: tb/radio_cmd_decoder_tb_top.sv
module radio_cmd_decoder_tb_top;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, csn = 1'b1;
  logic miso, xosc = 1'b1, rssi = 1'b0;
  logic tx_rd = 1'b0, rx_wr = 1'b0;
  logic [7:0] tx_data, rx_data = 8'h00;
  logic f_tx, f_rx, rxon, txcca, rfoff;

  int n_checks = 0, n_fail = 0;
  int c_ftx = 0, c_frx = 0, c_rxon = 0, c_txcca = 0, c_rfoff = 0;
  logic unf_model = 1'b0;
  logic [7:0] exp_q[$];
  string req_q[$];

  always #10 clk = ~clk;

  radio_cmd_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .spi_sclk_i(sclk), .spi_mosi_i(mosi),
    .spi_csn_i(csn), .spi_miso_o(miso), .xosc_stable_i(xosc),
    .rssi_valid_i(rssi), .radio_tx_rd_i(tx_rd), .radio_tx_data_o(tx_data),
    .radio_rx_wr_i(rx_wr), .radio_rx_data_i(rx_data), .flush_tx_o(f_tx),
    .flush_rx_o(f_rx), .rx_on_o(rxon), .tx_cca_o(txcca), .rf_off_o(rfoff));

  task automatic chk(input bit ok, input string req, input logic [7:0] act,
                     input logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (f_tx)  c_ftx++;
    if (f_rx)  c_frx++;
    if (rxon)  c_rxon++;
    if (txcca) c_txcca++;
    if (rfoff) c_rfoff++;
  end

  // monitor: assemble MISO bytes and compare against the scoreboard
  logic [7:0] mon_sh = 8'h00;
  int mon_n = 0;
  always @(posedge sclk or posedge csn) begin
    if (csn) mon_n = 0;
    else begin
      mon_sh = {mon_sh[6:0], miso};
      mon_n++;
      if (mon_n == 8) begin
        mon_n = 0;
        if (exp_q.size() == 0) chk(1'b0, "scoreboard-empty", mon_sh, 8'h00);
        else begin
          logic [7:0] e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          chk(mon_sh == e, r, mon_sh, e);
        end
      end
    end
  end

  function automatic logic [7:0] stat();
    return {xosc, rssi, 2'b00, unf_model, 3'b000};
  endfunction

  task automatic fb();
    csn = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic fe();
    repeat (6) @(negedge clk);
    csn = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic xb(input logic [7:0] tx, input logic [7:0] exp, input string req);
    exp_q.push_back(exp);
    req_q.push_back(req);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic one_op(input logic [7:0] op, input string req);
    fb(); xb(op, stat(), req); fe();
  endtask

  task automatic reg_wr(input logic [5:0] a, input logic [7:0] d, input string req);
    fb(); xb({2'b11, a}, stat(), req); xb(d, 8'h00, req); fe();
  endtask

  task automatic mem_rd1(input logic [11:0] a, input logic [7:0] exp, input string req);
    fb(); xb({4'b0001, a[11:8]}, stat(), req); xb(a[7:0], 8'h00, req);
    xb(8'h00, exp, req); fe();
  endtask

  task automatic tx_pop();
    tx_rd = 1'b1; @(negedge clk); tx_rd = 1'b0; @(negedge clk);
  endtask

  task automatic rx_push(input logic [7:0] d);
    rx_data = d; rx_wr = 1'b1; @(negedge clk); rx_wr = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", 8'h00, 8'h01);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    int ftx0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // reset state
    chk(miso == 1'b0, "R11 reset miso", {7'd0, miso}, 8'h00);
    chk(c_ftx + c_frx + c_rxon + c_txcca + c_rfoff == 0, "R9 reset strobes", 8'(c_ftx), 8'h00);
    chk(tx_data == 8'h00, "R6 reset tx empty", tx_data, 8'h00);

    // R1 status byte under two flag patterns
    one_op(8'h00, "R1");
    rssi = 1'b1;
    one_op(8'h00, "R1");

    // R2 register write, trailing bytes ignored
    reg_wr(6'h06, 8'h11, "R2");
    reg_wr(6'h00, 8'h99, "R2");
    fb(); xb(8'hC5, stat(), "R2"); xb(8'hA7, 8'h00, "R2"); xb(8'h3C, 8'h00, "R2"); fe();
    fb(); xb(8'h10, stat(), "R4"); xb(8'h05, 8'h00, "R4");
    xb(8'h00, 8'hA7, "R2"); xb(8'h00, 8'h11, "R2"); fe();

    // R3/R4 burst write and read with increment
    fb(); xb(8'h20, stat(), "R3"); xb(8'h40, 8'h00, "R3");
    xb(8'hDE, 8'h00, "R3"); xb(8'hAD, 8'h00, "R3"); xb(8'hBE, 8'h00, "R3"); fe();
    fb(); xb(8'h10, stat(), "R4"); xb(8'h40, 8'h00, "R4");
    xb(8'h00, 8'hDE, "R4"); xb(8'h00, 8'hAD, "R4"); xb(8'h00, 8'hBE, "R4"); fe();

    // R5 top of RAM and beyond
    fb(); xb(8'h21, stat(), "R5"); xb(8'hFE, 8'h00, "R5");
    xb(8'h5A, 8'h00, "R5"); xb(8'h6B, 8'h00, "R5"); xb(8'h7C, 8'h00, "R5"); fe();
    fb(); xb(8'h11, stat(), "R5"); xb(8'hFE, 8'h00, "R5");
    xb(8'h00, 8'h5A, "R5"); xb(8'h00, 8'h6B, "R5"); xb(8'h00, 8'h00, "R5"); fe();
    mem_rd1(12'h000, 8'h99, "R5 no alias");
    mem_rd1(12'hFFF, 8'h00, "R5 high addr");

    // R6 TX FIFO load and radio-side order
    one_op(8'h48, "R9");
    fb(); xb(8'h3A, stat(), "R6");
    xb(8'h11, 8'h00, "R6"); xb(8'h12, 8'h00, "R6"); xb(8'h13, 8'h00, "R6"); fe();
    mem_rd1(12'h100, 8'h11, "R6 base");
    chk(tx_data == 8'h11, "R6 head", tx_data, 8'h11); tx_pop();
    chk(tx_data == 8'h12, "R6 second", tx_data, 8'h12); tx_pop();
    chk(tx_data == 8'h13, "R6 third", tx_data, 8'h13); tx_pop();
    chk(tx_data == 8'h00, "R6 empty", tx_data, 8'h00);

    // R12 underflow sticky until TX flush
    tx_pop(); unf_model = 1'b1;
    one_op(8'h00, "R12 set");
    one_op(8'h00, "R12 sticky");
    ftx0 = c_ftx;
    one_op(8'h48, "R12");
    unf_model = 1'b0;
    chk(c_ftx == ftx0 + 1, "R9 flush_tx pulse", 8'(c_ftx - ftx0), 8'h01);
    one_op(8'h00, "R12 cleared");

    // R7 full TX FIFO drops the extra byte
    fb(); xb(8'h3A, stat(), "R7");
    for (int i = 0; i < 128; i++) xb(8'(i) ^ 8'h5A, 8'h00, "R7");
    xb(8'hEE, 8'h00, "R7"); fe();
    for (int i = 0; i < 128; i++) begin
      chk(tx_data == (8'(i) ^ 8'h5A), "R7 content", tx_data, 8'(i) ^ 8'h5A);
      tx_pop();
    end
    chk(tx_data == 8'h00, "R7 drained", tx_data, 8'h00);
    one_op(8'h00, "R7 no underflow");

    // R8 RX drain, empty, staged byte kept
    one_op(8'h47, "R9");
    rx_push(8'hA1); rx_push(8'hA2); rx_push(8'hA3);
    fb(); xb(8'h30, stat(), "R8"); xb(8'h00, 8'hA1, "R8"); xb(8'h00, 8'hA2, "R8"); fe();
    fb(); xb(8'h30, stat(), "R8"); xb(8'h00, 8'hA3, "R8 staged kept");
    xb(8'h00, 8'h00, "R8 empty"); xb(8'h00, 8'h00, "R8 empty"); fe();

    // R9 strobes and RX flush
    one_op(8'h42, "R9");
    chk(c_rxon == 1 && c_txcca == 0 && c_rfoff == 0, "R9 rx_on", 8'(c_rxon), 8'h01);
    one_op(8'h44, "R9");
    chk(c_txcca == 1 && c_rxon == 1 && c_rfoff == 0, "R9 tx_cca", 8'(c_txcca), 8'h01);
    one_op(8'h45, "R9");
    chk(c_rfoff == 1 && c_txcca == 1, "R9 rf_off", 8'(c_rfoff), 8'h01);
    rx_push(8'hB1); rx_push(8'hB2);
    one_op(8'h47, "R9");
    chk(c_frx == 2, "R9 flush_rx count", 8'(c_frx), 8'h02);
    fb(); xb(8'h30, stat(), "R9"); xb(8'h00, 8'h00, "R9 rx flushed"); fe();

    // R10 unimplemented opcode and no-op swallow later bytes
    fb(); xb(8'h80, stat(), "R10"); xb(8'hC0, 8'h00, "R10"); xb(8'h55, 8'h00, "R10"); fe();
    mem_rd1(12'h000, 8'h99, "R10 reg kept");
    ftx0 = c_ftx;
    fb(); xb(8'h00, stat(), "R10"); xb(8'h48, 8'h00, "R10"); fe();
    chk(c_ftx == ftx0, "R10 no strobe", 8'(c_ftx - ftx0), 8'h00);

    // R11 abort mid-byte and after opcode
    fb();
    for (int i = 7; i >= 4; i--) begin
      mosi = 1'b1;
      repeat (HALF) @(negedge clk); sclk = 1'b1;
      repeat (HALF) @(negedge clk); sclk = 1'b0;
    end
    fe();
    reg_wr(6'h01, 8'h33, "R11");
    mem_rd1(12'h001, 8'h33, "R11 fresh frame");
    reg_wr(6'h02, 8'h22, "R11");
    fb(); xb(8'hC2, stat(), "R11"); fe();
    one_op(8'h00, "R11");
    mem_rd1(12'h002, 8'h22, "R11 data not taken");

    chk(exp_q.size() == 0, "scoreboard drained", 8'(exp_q.size()), 8'h00);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule